// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master with Single-Wire Option

This block is a master for a serial peripheral bus. It moves one byte per transfer under the control of a small register file. Software sets the clock divider, the clock polarity and phase, and an operating mode, then writes a byte to the data register to start a transfer. While the byte is shifted, the serial clock runs at the system clock divided by 2×(N+1). The status register shows a busy flag while the transfer runs and a completion flag once the received byte has been stored. Reading the data register returns the received byte and clears the completion flag.

There are two operating modes. In full-duplex mode the block drives a data-out pin and samples a separate data-in pin. In single-wire mode one bidirectional pin carries the data. A direction bit then chooses whether the block drives the pin or listens on it. The pin has an output value and an output enable, so an external tri-state buffer can use it. Bit order can be most-significant first or least-significant first. All settings are captured when a transfer starts. A change made during a transfer therefore applies from the next byte.

Top module: `spim_top`

## Requirements
- R1: After reset, the mode register (address 0) and the status register (address 1) read 00h, the serial clock is low, and the pin output enable is 1.
- R2: The mode register keeps only bits 2:0. Bit 0 is LSB-first, bit 1 is single-wire mode, and bit 2 is the single-wire drive enable. Bits 7:3 always read 0, whatever value is written.
- R3: A write to the data register (address 2) while idle starts a transfer. Status bit 0 (busy) is 1 from the next cycle and returns to 0 exactly 16×(N+1) cycles after the write edge. N is the divider register (address 4).
- R4: While idle, the serial clock rests at the polarity bit (clock register address 3, bit 0). Its first change comes N+1 cycles after the write edge, and every later change comes N+1 cycles after the previous one.
- R5: When mode bit 0 is 0, the byte appears on the data-out pin MSB first. When it is 1, it appears LSB first. Received bits are placed in the same order.
- R6: In full-duplex mode (mode bit 1 = 0), bits are sampled from the data-in pin. The assembled byte reads back from the data register after the transfer.
- R7: In single-wire mode with the drive enable at 0, the pin output enable is 0 and bits are sampled from the shared pin input.
- R8: The pin output enable is 1 in full-duplex mode and in single-wire mode with the drive enable at 1. In single-wire mode the received byte always comes from the shared pin input.
- R9: Clock register bit 1 selects the phase. When it is 0, data is sampled on the first (leading) clock change of each bit and changed on the second. When it is 1, data changes on the leading change and is sampled on the trailing change.
- R10: Status bit 1 (complete) becomes 1 one cycle after busy falls. A read of the data register clears it.
- R11: A data register write while busy is ignored. The byte being sent and the transfer length do not change.
- R12: A mode register write while busy takes effect only when busy falls. Until then the pin output enable and the data source keep the values they had when the transfer started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select (0 mode, 1 status, 2 data, 3 clock, 4 divider) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the completion flag on a data read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| spi_clk | output | 1 | Serial clock |
| dq_out | output | 1 | Value driven onto the data-out / shared pin |
| dq_oe | output | 1 | Output enable for the data-out / shared pin |
| dq_in | input | 1 | Input from the shared pin |
| din | input | 1 | Data-in pin for full-duplex mode |

## Verification
With divider N, the write edge counts as cycle 0. The first serial clock change lands after edge N+1, busy falls after edge 16×(N+1), and the completion flag and received byte are ready one edge later. The driver counts falling edges from the write edge and checks each result at exactly its due cycle. It also checks the cycle just before busy falls, so an extra or missing tick is caught. A bench peripheral model follows the serial clock and feeds the scoreboard the byte it saw on the pin. That byte is compared against the queued expected byte at the sixteenth clock change, so bit order and phase are checked independently of the register readback.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int SPIM_DW     = 8;
    localparam int SPIM_BAUD_W = 8;
    localparam int SPIM_AW     = 3;

    typedef enum logic [SPIM_AW-1:0] {
        RA_MODE = 3'd0,
        RA_STAT = 3'd1,
        RA_DATA = 3'd2,
        RA_CLK  = 3'd3,
        RA_DIV  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic drive_en;
        logic one_wire;
        logic lsb_first;
    } mode_t;

    typedef struct packed {
        logic cpha;
        logic cpol;
    } clkcfg_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int CLK_W  = $bits(clkcfg_t);

    function automatic logic pin_drive(input mode_t m);
        return !m.one_wire || m.drive_en;
    endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
    import spim_pkg::*;
#(
    parameter int BW = SPIM_BAUD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [BW-1:0] div,
    output logic          tick
);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);

    AST_DIV_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= div)); // R4

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int W = SPIM_DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] tx_in,
    input  logic         lsb_first,
    input  logic         cpha,
    input  logic         tick,
    input  logic         sdi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx,
    output logic         sdo,
    output logic         phase
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          busy_q;
    logic          done_q;
    logic          phase_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  tx_q;
    logic [W-1:0]  rx_q;
    logic          sdo_q;

    function automatic logic [CW-1:0] wire_pos(input logic [CW-1:0] i, input logic lsb);
        return lsb ? i : (LAST - i);
    endfunction

    logic leading;
    assign leading = !phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            sdo_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                cnt_q   <= '0;
                tx_q    <= tx_in;
                rx_q    <= '0;
                sdo_q   <= tx_in[wire_pos('0, lsb_first)];
            end else if (busy_q && tick) begin
                phase_q <= !phase_q;
                if (leading) begin
                    if (!cpha) begin
                        rx_q[wire_pos(cnt_q, lsb_first)] <= sdi;
                    end else begin
                        sdo_q <= tx_q[wire_pos(cnt_q, lsb_first)];
                    end
                end else begin
                    if (cpha) begin
                        rx_q[wire_pos(cnt_q, lsb_first)] <= sdi;
                    end
                    if (cnt_q == LAST) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (!cpha) begin
                            sdo_q <= tx_q[wire_pos(cnt_q + 1'b1, lsb_first)];
                        end
                    end
                end
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign rx    = rx_q;
    assign sdo   = sdo_q;
    assign phase = phase_q;

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_q); // R3

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q); // R3

    AST_CLK_RESTS: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !phase_q); // R4

    AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(tx_q)); // R11

endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int W  = SPIM_DW,
    parameter int BW = SPIM_BAUD_W,
    parameter int AW = SPIM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          busy,
    input  logic          done,
    input  logic [W-1:0]  rx,
    output logic          start,
    output mode_t         act_mode,
    output clkcfg_t       act_clk,
    output logic [BW-1:0] act_div
);

    mode_t         mode_q,  mode_snap;
    clkcfg_t       clk_q,   clk_snap;
    logic [BW-1:0] div_q,   div_snap;
    logic [W-1:0]  rxd_q;
    logic          cmplt_q;

    logic wr_mode, wr_clk, wr_div, rd_data;
    assign wr_mode = wr && (addr == RA_MODE);
    assign wr_clk  = wr && (addr == RA_CLK);
    assign wr_div  = wr && (addr == RA_DIV);
    assign start   = wr && (addr == RA_DATA) && !busy;
    assign rd_data = rd && (addr == RA_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            clk_q     <= '0;
            div_q     <= '0;
            mode_snap <= '0;
            clk_snap  <= '0;
            div_snap  <= '0;
            rxd_q     <= '0;
            cmplt_q   <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= mode_t'(wdata[MODE_W-1:0]);
            if (wr_clk)  clk_q  <= clkcfg_t'(wdata[CLK_W-1:0]);
            if (wr_div)  div_q  <= wdata[BW-1:0];
            if (start) begin
                mode_snap <= mode_q;
                clk_snap  <= clk_q;
                div_snap  <= div_q;
                cmplt_q   <= 1'b0;
            end
            if (rd_data) cmplt_q <= 1'b0;
            if (done) begin
                cmplt_q <= 1'b1;
                rxd_q   <= rx;
            end
        end
    end

    assign act_mode = busy ? mode_snap : mode_q;
    assign act_clk  = busy ? clk_snap  : clk_q;
    assign act_div  = busy ? div_snap  : div_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_MODE: rdata[MODE_W-1:0] = mode_q;
            RA_STAT: rdata[1:0]        = {cmplt_q, busy};
            RA_DATA: rdata             = rxd_q;
            RA_CLK:  rdata[CLK_W-1:0]  = clk_q;
            RA_DIV:  rdata[BW-1:0]     = div_q;
            default: rdata             = '0;
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(act_mode) && $stable(act_clk) && $stable(act_div))); // R12

    AST_CMPLT_SET: assert property (@(posedge clk) disable iff (rst)
        done |=> cmplt_q); // R10

    AST_CMPLT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done) |=> !cmplt_q); // R10

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int W  = SPIM_DW,
    parameter int BW = SPIM_BAUD_W,
    parameter int AW = SPIM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic          spi_clk,
    output logic          dq_out,
    output logic          dq_oe,
    input  logic          dq_in,
    input  logic          din
);

    mode_t         act_mode;
    clkcfg_t       act_clk;
    logic [BW-1:0] act_div;
    logic          start, busy, done, tick, phase, sdo, sdi;
    logic [W-1:0]  rx;

    spim_regs #(.W(W), .BW(BW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .done     (done),
        .rx       (rx),
        .start    (start),
        .act_mode (act_mode),
        .act_clk  (act_clk),
        .act_div  (act_div)
    );

    spim_clkdiv #(.BW(BW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (act_div),
        .tick (tick)
    );

    assign sdi = act_mode.one_wire ? dq_in : din;

    spim_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tx_in     (reg_wdata),
        .lsb_first (act_mode.lsb_first),
        .cpha      (act_clk.cpha),
        .tick      (tick),
        .sdi       (sdi),
        .busy      (busy),
        .done      (done),
        .rx        (rx),
        .sdo       (sdo),
        .phase     (phase)
    );

    assign spi_clk = act_clk.cpol ^ phase;
    assign dq_out  = sdo;
    assign dq_oe   = pin_drive(act_mode);

    AST_OE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dq_oe)); // R12

endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;
    import spim_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;
    logic       spi_clk, dq_out, dq_oe, dq_in, din;

    always #10 clk = ~clk;

    spim_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_clk(spi_clk),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .din(din)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // peripheral model
    bit       s_cpha, s_lsb, s_on_pin, s_echo, s_line;
    bit [7:0] s_tx, s_cap;
    int       s_edges, s_bit;
    logic     prev_clk;

    typedef struct { bit chk; logic [7:0] v; } exp_t;
    exp_t exp_q[$];

    assign din   = s_on_pin ? ~s_line : s_line;
    assign dq_in = s_echo ? dq_out : (s_on_pin ? s_line : ~s_line);

    function automatic int wpos(input int i, input bit lsb);
        return lsb ? i : 7 - i;
    endfunction

    // monitor: follows the serial clock, pops the scoreboard at the 16th change
    always @(negedge clk) begin
        if (!rst && spi_clk !== prev_clk) begin
            s_edges++;
            if (s_edges % 2 == 1) begin
                if (!s_cpha) s_cap[wpos(s_bit, s_lsb)] = dq_out;
                else         s_line = s_tx[wpos(s_bit, s_lsb)];
            end else begin
                if (s_cpha) s_cap[wpos(s_bit, s_lsb)] = dq_out;
                s_bit++;
                if (!s_cpha && s_bit < 8) s_line = s_tx[wpos(s_bit, s_lsb)];
            end
            if (s_edges == 16) begin
                if (exp_q.size() == 0) begin
                    check("R5 scoreboard empty", 8'h00, 8'h01);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.chk) check("R5 R9 byte seen on pin", s_cap, e.v);
                end
            end
        end
        prev_clk = spi_clk;
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_data(output logic [7:0] v);
        reg_addr = RA_DATA; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer(input int n, input bit cpol, input bit cpha, input logic [2:0] mode,
                        input logic [7:0] tx, input logic [7:0] slv, input bit echo,
                        input bit chk_cap, input logic [7:0] exp_rx, input bit exp_oe,
                        input bit mid_data, input bit mid_mode);
        logic [7:0] v;
        int left;
        wr_reg(RA_DIV, 8'(n));
        wr_reg(RA_CLK, {6'b0, cpha, cpol});
        wr_reg(RA_MODE, {5'b0, mode});
        s_cpha = cpha; s_lsb = mode[0]; s_on_pin = mode[1]; s_echo = echo;
        s_tx = slv; s_cap = '0; s_bit = 0; s_edges = 0;
        s_line = slv[wpos(0, mode[0])];
        @(negedge clk);
        check("R4 idle clock level", {7'b0, spi_clk}, {7'b0, cpol});
        check("R7 R8 output enable", {7'b0, dq_oe}, {7'b0, exp_oe});
        exp_q.push_back('{chk_cap, tx});
        wr_reg(RA_DATA, tx);                     // now just after the write edge E0
        repeat (n) @(negedge clk);
        check("R4 clock before first change", {7'b0, spi_clk}, {7'b0, cpol});
        @(negedge clk);                          // after E(N+1)
        check("R4 first clock change", {7'b0, spi_clk}, {7'b0, ~cpol});
        left = 16 * (n + 1) - 1 - (n + 1);
        if (mid_data) begin
            wr_reg(RA_DATA, ~tx);                // R11: ignored while busy
            left--;
        end
        if (mid_mode) begin
            wr_reg(RA_MODE, 8'h02);              // R12: deferred
            left--;
            check("R12 enable held during byte", {7'b0, dq_oe}, 8'h01);
        end
        repeat (left) @(negedge clk);
        peek(RA_STAT, v);
        check("R3 busy one cycle before end", v & 8'h01, 8'h01);
        @(negedge clk);
        peek(RA_STAT, v);
        check("R3 busy falls on time", v & 8'h01, 8'h00);
        if (mid_mode) check("R12 new mode after byte", {7'b0, dq_oe}, 8'h00);
        @(negedge clk);
        peek(RA_STAT, v);
        check("R10 complete flag set", v, 8'h02);
        rd_data(v);
        check("R6 R7 R8 received byte", v, exp_rx);
        peek(RA_STAT, v);
        check("R10 complete flag cleared by read", v, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        s_cpha = 0; s_lsb = 0; s_on_pin = 0; s_echo = 0; s_line = 0;
        s_edges = 100; s_bit = 0; prev_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        peek(RA_MODE, v); check("R1 mode reset", v, 8'h00);
        peek(RA_STAT, v); check("R1 status reset", v, 8'h00);
        check("R1 clock reset", {7'b0, spi_clk}, 8'h00);
        check("R1 enable reset", {7'b0, dq_oe}, 8'h01);
        wr_reg(RA_MODE, 8'hF8);
        peek(RA_MODE, v); check("R2 reserved bits dropped", v, 8'h00);
        wr_reg(RA_MODE, 8'hFF);
        peek(RA_MODE, v); check("R2 low bits kept", v, 8'h07);
        // MSB first, phase 0, full duplex
        xfer(1, 0, 0, 3'b000, 8'hA5, 8'h3C, 0, 1, 8'h3C, 1, 0, 0);
        // LSB first, polarity 1, phase 1, fastest divider
        xfer(0, 1, 1, 3'b001, 8'h1E, 8'hC3, 0, 1, 8'hC3, 1, 0, 0);
        // phase 1, data write during byte ignored (R11)
        xfer(3, 0, 1, 3'b000, 8'h6B, 8'h94, 0, 1, 8'h94, 1, 1, 0);
        // single-wire listening: data from shared pin (R7)
        xfer(2, 1, 0, 3'b010, 8'h55, 8'hD2, 0, 0, 8'hD2, 0, 0, 0);
        // single-wire driving with echo (R8)
        xfer(1, 0, 0, 3'b110, 8'h3A, 8'h00, 1, 1, 8'h3A, 1, 0, 0);
        // mode write during byte deferred (R12)
        xfer(1, 0, 0, 3'b000, 8'hC7, 8'h19, 0, 1, 8'h19, 1, 0, 1);
        check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule